// File: doc/BRIEF.md
# Nested Priority Interrupt Arbiter

This block decides which interrupt a small 8-bit CPU takes next. Every maskable source owns a sticky request latch, an enable and a 2-bit software priority. The block also tracks the level the CPU is currently running at. Three non-maskable sources sit above all of them: the reset entry, a software trap and a top-level hardware interrupt. These ignore the current level.

Each cycle the block arbitrates in two stages. The highest software priority wins first. A fixed, exclusive hardware order then breaks any tie. The result is presented as a registered entry request with a vector index and a flag that says whether context (PC, X, A and condition code) must be stacked. When the CPU acknowledges the entry, the block clears the winning latch, saves the old level on a small internal stack and raises the current level. On return from interrupt, the level is reloaded from a value the CPU supplies. The top of the saved-level stack is visible so that the CPU can feed it back.

Top module: `irq_nest_arb`

## Requirements
- R1: Reset is synchronous and active high. On the first cycle after reset, `cur_lvl` is 3, `wake` is 1, and a reset entry is offered with `take_valid`=1, `take_vec`=0 and `take_stack`=0.
- R2: Vector codes are: 0 for reset, 1 for the top-level interrupt, 2 for the trap, and 3+i for maskable source i. Among eligible maskable sources, the one with the highest software priority is offered. Source i's priority is `irq_prio[2i+1:2i]`.
- R3: When eligible maskable sources share the highest software priority, the lowest-numbered source wins.
- R4: A maskable request is offered only when its enable is 1 and its priority is strictly greater than `cur_lvl`. Otherwise nothing is offered for it.
- R5: A request that is not offered stays latched. It is offered later, once its enable or a lower level makes it the winner.
- R6: `irq_clr[i]` discards source i's latched request, and it takes precedence over a request in the same cycle. A discarded request is never offered.
- R7: Non-maskable sources are offered regardless of `cur_lvl` and ahead of every maskable source. Their order is reset, then top-level interrupt, then trap.
- R8: An entry happens when `cpu_ack` is high while `take_valid` is high. On entry, the winning latch clears and `cur_lvl` becomes 3 for a non-maskable source, or the source's priority for a maskable one. Every entry except reset pushes the previous level, which then shows on `prev_lvl`.
- R9: `take_stack` is 1 for every offered vector except reset.
- R10: A top-level interrupt is offered and entered while a trap service is in progress at level 3.
- R11: `wake` is 1 whenever a non-maskable request is pending and 0 otherwise.
- R12: `cpu_iret` loads `cur_lvl` from `restore_lvl` and pops the saved-level stack.
- R13: All outputs are registered. A request or a state change shows on the outputs after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | NUM_SRC | Maskable request pulses, latched |
| irq_en | input | NUM_SRC | Per-source enable |
| irq_prio | input | 2*NUM_SRC | Per-source software priority, 2 bits each |
| irq_clr | input | NUM_SRC | Per-source latch clear |
| trap_req | input | 1 | Software trap pulse |
| tli_req | input | 1 | Top-level hardware interrupt pulse |
| cpu_ack | input | 1 | CPU takes the offered entry |
| cpu_iret | input | 1 | Return from interrupt |
| restore_lvl | input | 2 | Level reloaded on return |
| cur_lvl | output | 2 | Current CPU level |
| prev_lvl | output | 2 | Most recently saved level |
| take_valid | output | 1 | An entry is offered |
| take_vec | output | VEC_W | Offered vector index |
| take_stack | output | 1 | Context must be stacked for this entry |
| wake | output | 1 | Halt wake-up request |

## Verification
The bench builds the block with NUM_SRC=4 and STACK_DEPTH=4. With four sources, three software priorities can be shared between two sources, so the tie-break is exercised. A disabled level-3 source lets one maskable entry nest above another. Four saved levels are enough for the deepest nesting the bench reaches: a maskable entry, then a trap, then a top-level interrupt. Each entry is verified against a queue of expected vectors, and each return is checked against the popped level.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int LVL_W = 2;
  typedef logic [LVL_W-1:0] lvl_t;
  localparam lvl_t LVL_TOP = 2'd3;
  localparam int VEC_RST  = 0;
  localparam int VEC_TLI  = 1;
  localparam int VEC_TRAP = 2;
  localparam int VEC_BASE = 3;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] take_i,
  output logic [N-1:0] pend_nx,
  output logic [N-1:0] pend_q
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    // software clear dominates, a fresh request survives an entry clear
    assign pend_nx[g] = ((pend_q[g] & ~take_i[g]) | set_i[g]) & ~clr_i[g];
    always_ff @(posedge clk) begin
      if (rst) pend_q[g] <= 1'b0;
      else     pend_q[g] <= pend_nx[g];
    end
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_arb_pkg::*;
#(
  parameter int N = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]       pend,
  input  logic [N-1:0]       en,
  input  logic [2*N-1:0]     prio,
  input  lvl_t               cur,
  output logic               hit,
  output logic [IDX_W-1:0]   idx,
  output lvl_t               lvl
);
  lvl_t p;
  always_comb begin
    hit = 1'b0;
    idx = '0;
    lvl = '0;
    p   = '0;
    // walk from the weakest hardware slot down; >= lets lower index take ties
    for (int i = N - 1; i >= 0; i--) begin
      p = prio[2*i +: 2];
      if (pend[i] && en[i] && (p > cur) && (!hit || p >= lvl)) begin
        hit = 1'b1;
        idx = IDX_W'(i);
        lvl = p;
      end
    end
  end
endmodule

// File: rtl/lvl_stack.sv
module lvl_stack
  import irq_arb_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic push,
  input  logic pop,
  input  lvl_t din,
  output lvl_t top
);
  lvl_t s      [DEPTH];
  lvl_t dn_src [DEPTH];
  lvl_t up_src [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    if (g == 0) begin : g_first
      assign dn_src[g] = din;
    end else begin : g_mid
      assign dn_src[g] = s[g-1];
    end
    if (g == DEPTH - 1) begin : g_last
      assign up_src[g] = '0;
    end else begin : g_inner
      assign up_src[g] = s[g+1];
    end
    always_ff @(posedge clk) begin
      if (rst)              s[g] <= '0;
      else if (push && pop) s[g] <= (g == 0) ? din : s[g];
      else if (push)        s[g] <= dn_src[g];
      else if (pop)         s[g] <= up_src[g];
    end
  end

  assign top = s[0];
endmodule

// File: rtl/irq_nest_arb.sv
module irq_nest_arb
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC     = 8,
  parameter int STACK_DEPTH = 4,
  localparam int VEC_W      = $clog2(NUM_SRC + VEC_BASE)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_SRC-1:0]   irq_req,
  input  logic [NUM_SRC-1:0]   irq_en,
  input  logic [2*NUM_SRC-1:0] irq_prio,
  input  logic [NUM_SRC-1:0]   irq_clr,
  input  logic                 trap_req,
  input  logic                 tli_req,
  input  logic                 cpu_ack,
  input  logic                 cpu_iret,
  input  logic [1:0]           restore_lvl,
  output logic [1:0]           cur_lvl,
  output logic [1:0]           prev_lvl,
  output logic                 take_valid,
  output logic [VEC_W-1:0]     take_vec,
  output logic                 take_stack,
  output logic                 wake
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam logic [VEC_W-1:0] V_RST  = VEC_W'(VEC_RST);
  localparam logic [VEC_W-1:0] V_TLI  = VEC_W'(VEC_TLI);
  localparam logic [VEC_W-1:0] V_TRAP = VEC_W'(VEC_TRAP);
  localparam logic [VEC_W-1:0] V_BASE = VEC_W'(VEC_BASE);

  lvl_t             cur_lvl_q, take_lvl_q, lvl_base, lvl_nx, pick_lvl, lvl_d;
  logic             take_valid_q, take_stack_q, wake_q;
  logic [VEC_W-1:0] take_vec_q, vec_d;
  logic             valid_d, stack_d;
  logic             rst_pend_q, tli_q, trap_q;
  logic             rst_nx, tli_nx, trap_nx;
  logic             entry, nmi_entry;
  logic [NUM_SRC-1:0] take_m, pend_nx, pend_q;
  logic             pick_hit;
  logic [IDX_W-1:0] pick_idx;

  assign entry     = cpu_ack & take_valid_q;
  assign nmi_entry = entry & (take_vec_q < V_BASE);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_take
    assign take_m[g] = entry && (take_vec_q == VEC_W'(VEC_BASE + g));
  end

  irq_pend_bank #(.N(NUM_SRC)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .set_i  (irq_req),
    .clr_i  (irq_clr),
    .take_i (take_m),
    .pend_nx(pend_nx),
    .pend_q (pend_q)
  );

  // non-maskable latches, cleared only by their own entry
  assign rst_nx  = rst_pend_q & ~(entry && take_vec_q == V_RST);
  assign tli_nx  = (tli_q  & ~(entry && take_vec_q == V_TLI))  | tli_req;
  assign trap_nx = (trap_q & ~(entry && take_vec_q == V_TRAP)) | trap_req;

  // return first, then a same-cycle entry stacks the restored level
  assign lvl_base = cpu_iret ? lvl_t'(restore_lvl) : cur_lvl_q;
  assign lvl_nx   = !entry   ? lvl_base :
                    nmi_entry ? LVL_TOP : take_lvl_q;

  lvl_stack #(.DEPTH(STACK_DEPTH)) u_stack (
    .clk (clk),
    .rst (rst),
    .push(entry && take_vec_q != V_RST),
    .pop (cpu_iret),
    .din (lvl_base),
    .top (prev_lvl)
  );

  irq_pick #(.N(NUM_SRC)) u_pick (
    .pend(pend_nx),
    .en  (irq_en),
    .prio(irq_prio),
    .cur (lvl_nx),
    .hit (pick_hit),
    .idx (pick_idx),
    .lvl (pick_lvl)
  );

  always_comb begin
    valid_d = 1'b1;
    stack_d = 1'b1;
    lvl_d   = LVL_TOP;
    vec_d   = V_RST;
    if (rst_nx) begin
      stack_d = 1'b0;
    end else if (tli_nx) begin
      vec_d = V_TLI;
    end else if (trap_nx) begin
      vec_d = V_TRAP;
    end else if (pick_hit) begin
      vec_d = VEC_W'(pick_idx) + V_BASE;
      lvl_d = pick_lvl;
    end else begin
      valid_d = 1'b0;
      stack_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_lvl_q    <= LVL_TOP;
      rst_pend_q   <= 1'b1;
      tli_q        <= 1'b0;
      trap_q       <= 1'b0;
      take_valid_q <= 1'b1;
      take_vec_q   <= V_RST;
      take_stack_q <= 1'b0;
      take_lvl_q   <= LVL_TOP;
      wake_q       <= 1'b1;
    end else begin
      cur_lvl_q    <= lvl_nx;
      rst_pend_q   <= rst_nx;
      tli_q        <= tli_nx;
      trap_q       <= trap_nx;
      take_valid_q <= valid_d;
      take_vec_q   <= vec_d;
      take_stack_q <= stack_d;
      take_lvl_q   <= lvl_d;
      wake_q       <= rst_nx | tli_nx | trap_nx;
    end
  end

  assign cur_lvl    = cur_lvl_q;
  assign take_valid = take_valid_q;
  assign take_vec   = take_vec_q;
  assign take_stack = take_stack_q;
  assign wake       = wake_q;
endmodule

// File: rtl/irq_nest_arb_chk.sv
module irq_nest_arb_chk #(
  parameter int NUM_SRC = 8,
  parameter int VEC_W   = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             cpu_ack,
  input logic             cpu_iret,
  input logic [1:0]       restore_lvl,
  input logic [1:0]       cur_lvl,
  input logic             take_valid,
  input logic [VEC_W-1:0] take_vec,
  input logic             take_stack,
  input logic             wake
);
  localparam logic [VEC_W-1:0] FIRST_MASK = VEC_W'(3);

  // R1
  reset_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (take_valid && take_vec == '0 && cur_lvl == 2'd3));

  // R9
  reset_nostack_chk: assert property (@(posedge clk) disable iff (rst)
    (take_valid && take_vec == '0) |-> !take_stack);

  // R9
  other_stack_chk: assert property (@(posedge clk) disable iff (rst)
    (take_valid && take_vec != '0) |-> take_stack);

  // R8
  nmi_top_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_ack && take_valid && take_vec < FIRST_MASK) |=> (cur_lvl == 2'd3));

  // R4
  mask_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_ack && take_valid && take_vec >= FIRST_MASK && !cpu_iret)
      |=> (cur_lvl > $past(cur_lvl)));

  // R12
  iret_restore_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_iret && !(cpu_ack && take_valid)) |=> (cur_lvl == $past(restore_lvl)));

  // R11
  nmi_wake_chk: assert property (@(posedge clk) disable iff (rst)
    (take_valid && take_vec < FIRST_MASK) |-> wake);
endmodule

bind irq_nest_arb irq_nest_arb_chk #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cpu_ack    (cpu_ack),
  .cpu_iret   (cpu_iret),
  .restore_lvl(restore_lvl),
  .cur_lvl    (cur_lvl),
  .take_valid (take_valid),
  .take_vec   (take_vec),
  .take_stack (take_stack),
  .wake       (wake)
);

// File: tb/irq_nest_arb_tb.sv
module irq_nest_arb_tb;
  localparam int CLK_P = 10;
  localparam int NS    = 4;
  localparam int VW    = $clog2(NS + 3);

  logic clk = 0, rst = 1;
  logic [NS-1:0]   irq_req = '0, irq_en = '0, irq_clr = '0;
  logic [2*NS-1:0] irq_prio = '0;
  logic trap_req = 0, tli_req = 0, cpu_ack = 0, cpu_iret = 0;
  logic [1:0] restore_lvl = '0, cur_lvl, prev_lvl;
  logic take_valid, take_stack, wake;
  logic [VW-1:0] take_vec;

  int checks = 0, errors = 0;
  int exp_q[$];

  always #(CLK_P/2) clk = ~clk;

  irq_nest_arb #(.NUM_SRC(NS), .STACK_DEPTH(4)) u_dut (
    .clk(clk), .rst(rst), .irq_req(irq_req), .irq_en(irq_en),
    .irq_prio(irq_prio), .irq_clr(irq_clr), .trap_req(trap_req),
    .tli_req(tli_req), .cpu_ack(cpu_ack), .cpu_iret(cpu_iret),
    .restore_lvl(restore_lvl), .cur_lvl(cur_lvl), .prev_lvl(prev_lvl),
    .take_valid(take_valid), .take_vec(take_vec),
    .take_stack(take_stack), .wake(wake)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // driver: record the expected entry, then acknowledge it
  task automatic enter(int v, int s);
    exp_q.push_back(v * 2 + s);
    cpu_ack = 1;
    tick();
    cpu_ack = 0;
  endtask

  task automatic ret(int lv);
    restore_lvl = 2'(lv);
    cpu_iret = 1;
    tick();
    cpu_iret = 0;
  endtask

  task automatic offer(string req, int v);
    check({req, " valid"}, int'(take_valid), 1);
    check({req, " vec"}, int'(take_vec), v);
  endtask

  // monitor: compare each taken entry with the scoreboard
  always @(negedge clk) begin
    if (!rst && cpu_ack && take_valid) begin
      if (exp_q.size() == 0) begin
        check("R8 unexpected entry", int'(take_vec), -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        check("R2/R9 entry vec*2+stack", int'(take_vec) * 2 + int'(take_stack), e);
      end
    end
  end

  initial begin
    #(CLK_P * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(); tick();
    rst = 0;
    tick();
    // R1 reset entry
    offer("R1", 0);
    check("R1 stack", int'(take_stack), 0);
    check("R1 lvl", int'(cur_lvl), 3);
    check("R1 wake", int'(wake), 1);
    enter(0, 0);
    check("R13 idle", int'(take_valid), 0);
    check("R11 wake low", int'(wake), 0);
    ret(0);
    check("R12 lvl", int'(cur_lvl), 0);

    // src0=1, src1=2, src2=2, src3=3 (src3 disabled)
    irq_prio = {2'd3, 2'd2, 2'd2, 2'd1};
    irq_en   = 4'b0111;
    irq_req  = 4'b1111;
    tick();
    irq_req  = '0;
    offer("R2 R3 R13", 4);
    enter(4, 1);
    check("R8 lvl", int'(cur_lvl), 2);
    check("R8 prev", int'(prev_lvl), 0);
    check("R4 equal prio blocked", int'(take_valid), 0);
    irq_en = 4'b1111;
    tick();
    offer("R5 enable", 6);
    enter(6, 1);
    check("R8 lvl3", int'(cur_lvl), 3);
    check("R8 prev2", int'(prev_lvl), 2);
    ret(2);
    check("R12 lvl2", int'(cur_lvl), 2);
    check("R12 pop", int'(prev_lvl), 0);
    check("R4 still blocked", int'(take_valid), 0);
    ret(0);
    offer("R5 level drop", 5);
    enter(5, 1);
    ret(0);
    offer("R5 low prio", 3);
    enter(3, 1);
    check("R8 lvl1", int'(cur_lvl), 1);
    ret(0);
    check("R5 drained", int'(take_valid), 0);

    // R6 clear discards
    irq_en  = 4'b1110;
    irq_req = 4'b0001;
    tick();
    irq_req = '0;
    check("R4 disabled", int'(take_valid), 0);
    irq_clr = 4'b0001;
    tick();
    irq_clr = '0;
    irq_en  = 4'b1111;
    tick(); tick();
    check("R6 discarded", int'(take_valid), 0);
    irq_req = 4'b0010;
    irq_clr = 4'b0010;
    tick();
    irq_req = '0;
    irq_clr = '0;
    tick();
    check("R6 clear wins", int'(take_valid), 0);

    // R7 R10 non-maskable nesting above level 3
    irq_req = 4'b1000;
    tick();
    irq_req = '0;
    offer("R2", 6);
    enter(6, 1);
    trap_req = 1;
    tick();
    trap_req = 0;
    offer("R7 trap at lvl3", 2);
    check("R9 trap stack", int'(take_stack), 1);
    check("R11 wake", int'(wake), 1);
    enter(2, 1);
    check("R8 trap lvl", int'(cur_lvl), 3);
    tli_req = 1;
    tick();
    tli_req = 0;
    offer("R10 tli over trap", 1);
    enter(1, 1);
    check("R8 tli lvl", int'(cur_lvl), 3);
    check("R11 wake clear", int'(wake), 0);
    ret(3); ret(3); ret(0);
    check("R12 unwound", int'(cur_lvl), 0);

    // R7 order with everything at once
    tli_req = 1; trap_req = 1; irq_req = 4'b1000;
    tick();
    tli_req = 0; trap_req = 0; irq_req = '0;
    offer("R7 tli first", 1);
    enter(1, 1);
    offer("R7 trap next", 2);
    enter(2, 1);
    check("R7 mask held", int'(take_valid), 0);
    ret(3);
    check("R4 at lvl3", int'(take_valid), 0);
    ret(0);
    offer("R5 after nmi", 6);
    enter(6, 1);
    ret(0);
    tick();
    check("R8 scoreboard empty", exp_q.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule